// File: doc/BRIEF.md
# Serial Controller Register Bank with Masked Interrupt

This block is the software-visible register file of a serial bus controller. It decodes a word-addressed read/write port into a control word, a target address, a transmit byte, a transfer length, a read-only status word, an interrupt status register and an interrupt mask. Every write passes through a merge step. Bits that are read-only or write-one-to-clear, and bits above the register width, keep their stored value. Write-one-to-clear bits written as 1 are then cleared.

The transfer engine is a separate block. It reports events through one set pulse per interrupt status bit and supplies the live status word. The bank combines the interrupt status with the mask into one level-sensitive interrupt line. Software cannot write the mask directly. It unmasks bits through an enable register and masks bits through a disable register. A write to the control word with bit 6 at 1 gives a one-cycle FIFO clear pulse to the engine.

Top module: `sbc_regbank`

## Requirements
- R1: The word index is `bus_addr[5:2]`: 0 control, 1 status, 2 target address, 3 transmit byte, 4 interrupt status, 5 transfer length, 8 mask, 9 enable, 10 disable. Reads of any other index return 0, and writes to them change no register or output.
- R2: Read data is zero-extended from the register width: control 16, status 9, target address 10, transmit byte 8, interrupt status 10, transfer length 8, mask 10.
- R3: Control bits 6 and 7 always read 0. The other control bits take the written value and appear on `ctrl_o` (divider A in bits 15:14, divider B in 13:8, hold 4, ack enable 3, 7-bit addressing 2, read-not-write 0). A control write with data bit 6 at 1 raises `fifo_clr_o` for exactly the next cycle.
- R4: The status register reads the value `status_in` had one cycle before the read. Writes to it have no effect.
- R5: An `evt_set` bit at 1 sets the matching interrupt status bit at the next edge. Writing 1 to interrupt status bits in mask 0x2FF clears them. Bit 8 is not cleared by any write.
- R6: When an event set pulse and a software clear hit the same interrupt status bit in the same cycle, the bit ends up set.
- R7: The mask register resets to 0x2FF and ignores direct writes.
- R8: Writing the enable register clears the mask bits written as 1. Writing the disable register sets them. Both registers read back 0.
- R9: `irq_o` is high exactly when some interrupt status bit is 1 while its mask bit is 0. It follows the registers in the same cycle.
- R10: After reset every register reads 0 except the mask (0x2FF) and the status (which tracks `status_in`), and `irq_o` is low.
- R11: Read data is registered. A read sampled at an edge presents the pre-edge register value on `bus_rdata` after that edge and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| status_in | input | 9 | Live status word from the transfer engine |
| evt_set | input | 10 | Per-bit interrupt set pulses |
| ctrl_o | output | 16 | Stored control word |
| tgt_addr_o | output | 10 | Stored target address |
| tx_byte_o | output | 8 | Stored transmit byte |
| xfer_len_o | output | 8 | Stored transfer length |
| fifo_clr_o | output | 1 | One-cycle FIFO clear request |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that reads and writes are never strobed in the same cycle, and that the enable and disable registers are never written together. A single address carries both strobes, so the second case cannot arise. They also assume that set pulses for bit 8 come only from the engine. The stimulus drives one access at a time, each held for one full cycle. It raises event pulses either alone or together with an interrupt status write, and only when it is exercising the set-over-clear rule.

// File: rtl/sbc_reg_pkg.sv
package sbc_reg_pkg;

    localparam int BUS_W   = 32;
    localparam int CTRL_W  = 16;
    localparam int STAT_W  = 9;
    localparam int TADR_W  = 10;
    localparam int TXB_W   = 8;
    localparam int ISR_W   = 10;
    localparam int LEN_W   = 8;
    localparam int MASK_W  = 10;

    localparam logic [CTRL_W-1:0] CTRL_RO  = 16'h00C0;
    localparam logic [ISR_W-1:0]  ISR_WTC  = 10'h2FF;
    localparam logic [ISR_W-1:0]  ISR_RO   = 10'h100;
    localparam logic [MASK_W-1:0] MASK_RST = 10'h2FF;
    localparam int                CLR_BIT  = 6;

    typedef enum logic [3:0] {
        IX_CTRL = 4'd0,
        IX_STAT = 4'd1,
        IX_TADR = 4'd2,
        IX_TXB  = 4'd3,
        IX_ISR  = 4'd4,
        IX_LEN  = 4'd5,
        IX_MASK = 4'd8,
        IX_IEN  = 4'd9,
        IX_IDIS = 4'd10
    } reg_ix_e;

    typedef struct packed {
        logic ctrl;
        logic stat;
        logic tadr;
        logic txb;
        logic isr;
        logic len;
        logic mask;
        logic ien;
        logic idis;
    } reg_hit_t;

endpackage

// File: rtl/sbc_reg_decode.sv
module sbc_reg_decode
    import sbc_reg_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic [AW-1:0] addr,
    output reg_hit_t      hit
);
    localparam int IX_W = AW - 2;

    logic [IX_W-1:0] ix;
    assign ix = addr[AW-1:2];

    always_comb begin
        hit = '0;
        case (ix)
            IX_W'(IX_CTRL): hit.ctrl = 1'b1;
            IX_W'(IX_STAT): hit.stat = 1'b1;
            IX_W'(IX_TADR): hit.tadr = 1'b1;
            IX_W'(IX_TXB):  hit.txb  = 1'b1;
            IX_W'(IX_ISR):  hit.isr  = 1'b1;
            IX_W'(IX_LEN):  hit.len  = 1'b1;
            IX_W'(IX_MASK): hit.mask = 1'b1;
            IX_W'(IX_IEN):  hit.ien  = 1'b1;
            IX_W'(IX_IDIS): hit.idis = 1'b1;
            default:        hit      = '0;
        endcase
    end

    // R1: at most one register selected per access
    a_r1_onehot_hit: assert final ($onehot0(hit));

endmodule

// File: rtl/sbc_reg_field.sv
module sbc_reg_field #(
    parameter int             W     = 8,
    parameter int             BW    = 32,
    parameter logic [W-1:0]   RO    = '0,
    parameter logic [W-1:0]   WTC   = '0,
    parameter logic [W-1:0]   RST   = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [BW-1:0] wdata,
    input  logic [W-1:0]  set_i,
    output logic [W-1:0]  q
);
    localparam logic [W-1:0] KEEP = RO | WTC;

    typedef struct packed {
        logic [W-1:0] val;
    } fld_t;

    fld_t fld_d, fld_q;
    logic [W-1:0] wr_val;
    logic [W-1:0] merged;

    assign wr_val = wdata[W-1:0];

    always_comb begin
        merged    = (wr_val & ~KEEP) | (fld_q.val & KEEP);
        merged    = merged & ~(wr_val & WTC);
        fld_d     = fld_q;
        if (wr_hit) begin
            fld_d.val = merged;
        end
        fld_d.val = fld_d.val | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q.val <= RST;
        end else begin
            fld_q <= fld_d;
        end
    end

    assign q = fld_q.val;

    // R5: a set pulse lands at the next edge
    a_r5_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((q & $past(set_i)) == $past(set_i)));

    // R6: set wins over a simultaneous clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (|(set_i & wr_val & WTC))) |=>
        ((q & $past(set_i)) == $past(set_i)));

    // R3 and R5: read-only bits hold unless set by the engine
    a_r3_r5_ro_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & RO) == '0) |=> ((q & RO) == ($past(q) & RO)));

    // R5: a clearing write with no set leaves the cleared bits low
    a_r5_wtc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (set_i == '0)) |=> ((q & $past(wr_val & WTC)) == '0));

endmodule

// File: rtl/sbc_irq_ctrl.sv
module sbc_irq_ctrl #(
    parameter int           W   = 10,
    parameter logic [W-1:0] RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_wr,
    input  logic         dis_wr,
    input  logic [W-1:0] wval,
    input  logic [W-1:0] isr,
    output logic [W-1:0] mask_q,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] mask;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_wr) begin
            st_d.mask = st_q.mask & ~wval;
        end else if (dis_wr) begin
            st_d.mask = st_q.mask | wval;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask <= RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q = st_q.mask;
    assign irq    = |(isr & ~st_q.mask);

    // R7: the mask moves only on enable or disable writes
    a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_wr && !dis_wr) |=> $stable(mask_q));

    // R8: enable clears the written bits
    a_r8_enable: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> ((mask_q & $past(wval)) == '0));

    // R8: disable sets the written bits
    a_r8_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_wr && !en_wr) |=> ((mask_q & $past(wval)) == $past(wval)));

endmodule

// File: rtl/sbc_regbank.sv
module sbc_regbank
    import sbc_reg_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [STAT_W-1:0] status_in,
    input  logic [ISR_W-1:0]  evt_set,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [TADR_W-1:0] tgt_addr_o,
    output logic [TXB_W-1:0]  tx_byte_o,
    output logic [LEN_W-1:0]  xfer_len_o,
    output logic              fifo_clr_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [BUS_W-1:0]  rdata;
        logic [STAT_W-1:0] status;
        logic              fifo_clr;
    } top_st_t;

    top_st_t  st_d, st_q;
    reg_hit_t hit;
    reg_hit_t wr_hit;
    logic [ISR_W-1:0]  isr_q;
    logic [MASK_W-1:0] mask_q;
    logic [BUS_W-1:0]  rd_mux;

    sbc_reg_decode #(.AW(AW)) u_decode (
        .addr (bus_addr),
        .hit  (hit)
    );

    assign wr_hit = bus_wr ? hit : '0;

    sbc_reg_field #(.W(CTRL_W), .BW(BUS_W), .RO(CTRL_RO)) u_ctrl (
        .clk (clk), .rst_n (rst_n), .wr_hit (wr_hit.ctrl),
        .wdata (bus_wdata), .set_i ('0), .q (ctrl_o)
    );

    sbc_reg_field #(.W(TADR_W), .BW(BUS_W)) u_tadr (
        .clk (clk), .rst_n (rst_n), .wr_hit (wr_hit.tadr),
        .wdata (bus_wdata), .set_i ('0), .q (tgt_addr_o)
    );

    sbc_reg_field #(.W(TXB_W), .BW(BUS_W)) u_txb (
        .clk (clk), .rst_n (rst_n), .wr_hit (wr_hit.txb),
        .wdata (bus_wdata), .set_i ('0), .q (tx_byte_o)
    );

    sbc_reg_field #(.W(LEN_W), .BW(BUS_W)) u_len (
        .clk (clk), .rst_n (rst_n), .wr_hit (wr_hit.len),
        .wdata (bus_wdata), .set_i ('0), .q (xfer_len_o)
    );

    sbc_reg_field #(.W(ISR_W), .BW(BUS_W), .RO(ISR_RO), .WTC(ISR_WTC)) u_isr (
        .clk (clk), .rst_n (rst_n), .wr_hit (wr_hit.isr),
        .wdata (bus_wdata), .set_i (evt_set), .q (isr_q)
    );

    sbc_irq_ctrl #(.W(MASK_W), .RST(MASK_RST)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_wr  (wr_hit.ien),
        .dis_wr (wr_hit.idis),
        .wval   (bus_wdata[MASK_W-1:0]),
        .isr    (isr_q),
        .mask_q (mask_q),
        .irq    (irq_o)
    );

    always_comb begin
        rd_mux = '0;
        if (hit.ctrl) rd_mux = BUS_W'(ctrl_o);
        if (hit.stat) rd_mux = BUS_W'(st_q.status);
        if (hit.tadr) rd_mux = BUS_W'(tgt_addr_o);
        if (hit.txb)  rd_mux = BUS_W'(tx_byte_o);
        if (hit.isr)  rd_mux = BUS_W'(isr_q);
        if (hit.len)  rd_mux = BUS_W'(xfer_len_o);
        if (hit.mask) rd_mux = BUS_W'(mask_q);
    end

    always_comb begin
        st_d          = st_q;
        st_d.status   = status_in;
        st_d.fifo_clr = wr_hit.ctrl & bus_wdata[CLR_BIT];
        if (bus_rd) begin
            st_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rdata    <= '0;
            st_q.status   <= '0;
            st_q.fifo_clr <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = st_q.rdata;
    assign fifo_clr_o = st_q.fifo_clr;

    // R3: a clearing control write yields the pulse on the next cycle
    a_r3_clr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit.ctrl && bus_wdata[CLR_BIT]) |=> fifo_clr_o);

    // R1: writes to unmapped words leave every stored output unchanged
    a_r1_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (hit == '0) && (evt_set == '0)) |=>
        ($stable(ctrl_o) && $stable(tgt_addr_o) && $stable(tx_byte_o) &&
         $stable(xfer_len_o) && $stable(isr_q) && $stable(mask_q)));

    // R9: an unmasked event raises the line on the next cycle
    a_r9_irq_follows_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(evt_set & ~mask_q)) && !wr_hit.idis) |=> irq_o);

    // R11: read data is held when no read is strobed
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/sbc_regbank_tb.sv
module sbc_regbank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [8:0]  status_in = '0;
    logic [9:0]  evt_set = '0;
    logic [15:0] ctrl_o;
    logic [9:0]  tgt_addr_o;
    logic [7:0]  tx_byte_o;
    logic [7:0]  xfer_len_o;
    logic        fifo_clr_o;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    sbc_regbank u_dut (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_rd (bus_rd), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .status_in (status_in), .evt_set (evt_set), .ctrl_o (ctrl_o),
        .tgt_addr_o (tgt_addr_o), .tx_byte_o (tx_byte_o),
        .xfer_len_o (xfer_len_o), .fifo_clr_o (fifo_clr_o), .irq_o (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [5:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [9:0] v);
        @(negedge clk);
        evt_set = v;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // monitor: compare registered read data against the scoreboard
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected read", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10 reset state
        check("R10 irq after reset", 32'(irq_o), 32'h0);
        rd_exp(6'h00, 32'h0, "R10 ctrl");
        rd_exp(6'h08, 32'h0, "R10 tadr");
        rd_exp(6'h10, 32'h0, "R10 isr");
        rd_exp(6'h20, 32'h2FF, "R10 R7 mask");

        // R2 truncation
        wr(6'h08, 32'hFFFF_FFFF);
        rd_exp(6'h08, 32'h3FF, "R2 tadr width");
        wr(6'h0C, 32'hFFFF_FFFF);
        rd_exp(6'h0C, 32'hFF, "R2 txb width");
        wr(6'h14, 32'h1234_5678);
        rd_exp(6'h14, 32'h78, "R2 len width");

        // R3 control, clear pulse
        @(negedge clk);
        bus_addr = 6'h00; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R3 clr pulse high", 32'(fifo_clr_o), 32'h1);
        @(negedge clk);
        check("R3 clr pulse one cycle", 32'(fifo_clr_o), 32'h0);
        rd_exp(6'h00, 32'hFF3F, "R3 ctrl ro bits");
        wr(6'h00, 32'h0000_C10D);
        check("R3 no clr pulse", 32'(fifo_clr_o), 32'h0);
        check("R3 divider A", 32'(ctrl_o[15:14]), 32'h3);
        check("R3 divider B", 32'(ctrl_o[13:8]), 32'h1);
        check("R3 rnw and nea", 32'({ctrl_o[2], ctrl_o[0]}), 32'h3);

        // R4 status
        @(negedge clk);
        status_in = 9'h1A5;
        @(negedge clk);
        rd_exp(6'h04, 32'h1A5, "R4 status tracks input");
        wr(6'h04, 32'h0);
        rd_exp(6'h04, 32'h1A5, "R4 status write ignored");

        // R1 unmapped
        wr(6'h18, 32'hFFFF_FFFF);
        wr(6'h30, 32'hFFFF_FFFF);
        rd_exp(6'h18, 32'h0, "R1 unmapped read");
        rd_exp(6'h00, 32'hC10D, "R1 ctrl untouched");
        rd_exp(6'h20, 32'h2FF, "R1 mask untouched");
        rd_exp(6'h10, 32'h0, "R1 isr untouched");
        check("R1 tadr output", 32'(tgt_addr_o), 32'h3FF);

        // R5 set and clear
        pulse(10'h0FF);
        rd_exp(6'h10, 32'hFF, "R5 set pulses");
        check("R9 all masked", 32'(irq_o), 32'h0);
        wr(6'h10, 32'h0F);
        rd_exp(6'h10, 32'hF0, "R5 partial clear");
        wr(6'h10, 32'hF0);
        rd_exp(6'h10, 32'h0, "R5 full clear");

        // R6 set wins
        pulse(10'h003);
        @(negedge clk);
        bus_addr = 6'h10; bus_wdata = 32'h3; bus_wr = 1'b1; evt_set = 10'h001;
        @(negedge clk);
        bus_wr = 1'b0; evt_set = '0;
        rd_exp(6'h10, 32'h1, "R6 set beats clear");

        // R8 enable/disable, R9 irq
        wr(6'h24, 32'h005);
        rd_exp(6'h20, 32'h2FA, "R8 enable clears");
        check("R9 irq unmasked", 32'(irq_o), 32'h1);
        rd_exp(6'h24, 32'h0, "R8 enable reads zero");
        wr(6'h28, 32'h001);
        check("R9 irq masked again", 32'(irq_o), 32'h0);
        rd_exp(6'h20, 32'h2FB, "R8 disable sets");
        rd_exp(6'h28, 32'h0, "R8 disable reads zero");

        // R7 direct mask write ignored
        wr(6'h20, 32'h0);
        rd_exp(6'h20, 32'h2FB, "R7 mask write ignored");

        // R9 unmasked event
        pulse(10'h004);
        check("R9 event raises irq", 32'(irq_o), 32'h1);
        wr(6'h10, 32'h3FF);
        check("R9 clear drops irq", 32'(irq_o), 32'h0);

        // R5 bit 8 read-only
        pulse(10'h100);
        wr(6'h10, 32'h3FF);
        rd_exp(6'h10, 32'h100, "R5 bit 8 not clearable");
        check("R9 bit 8 unmasked", 32'(irq_o), 32'h1);
        wr(6'h28, 32'h100);
        check("R9 bit 8 masked", 32'(irq_o), 32'h0);

        // R10 second reset
        do_reset();
        rd_exp(6'h20, 32'h2FF, "R10 mask after reset");
        rd_exp(6'h10, 32'h0, "R10 isr after reset");
        check("R10 irq low", 32'(irq_o), 32'h0);

        repeat (3) @(negedge clk);
        check("R11 scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule